// File: doc/BRIEF.md
# Interrupt Polarity Mask Aggregator

This block collects seven level status signals from an audio codec's monitoring logic. The sources are thermal shutdown, headphone presence, three general-purpose inputs, microphone bias level detect and microphone bias short. Each raw signal is asynchronous, so it first passes through a two-stage synchronizer. Each source then has its own polarity selection and its own enable bit. The enabled sources are ORed into one interrupt request.

The request feeds a small output state machine. A two-bit mode field sets how the request reaches the pin: never driven, open-drain active low, push-pull active high or push-pull active low. The block outputs a pin data value and an output enable, so a pad cell outside the block can build the open-drain case. Three 9-bit registers hold the configuration, and a simple write/read port reaches them.

The output state machine has three states:
- QUIET: the output is off.
- RELEASED: the output is enabled and no request is pending.
- ACTIVE: a request is pending.

It has four named transitions:
- ARM: QUIET to RELEASED or ACTIVE when the mode leaves 00.
- FIRE: RELEASED to ACTIVE when the request rises.
- CLEAR: ACTIVE to RELEASED when the request falls.
- DISARM: any state to QUIET when the mode returns to 00.

Top module: `codec_irq_combiner`

## Requirements
- R1: After reset, all three registers read 0 and `irq_oe` and `irq_o` are 0.
- R2: The source-polarity register sits at address 0x19, the source-enable register at 0x1A and the output-control register at 0x1B. Each register reads back what was written, except that unused bits read 0. The unused bits are bits 8 and 2 of the polarity and enable registers, and bits 6:0 of the control register.
- R3: A write to any address other than 0x19, 0x1A or 0x1B leaves all three registers unchanged.
- R4: In the polarity and enable registers, the sources sit at these bits:

  | Bit | Source |
  |-----|--------|
  | 0 | microphone short (`micshort_i`) |
  | 1 | microphone detect (`micdet_i`) |
  | 3 | `gpin_i[0]` |
  | 4 | `gpin_i[1]` |
  | 5 | `gpin_i[2]` |
  | 6 | headphone (`hp_i`) |
  | 7 | thermal (`therm_i`) |

- R5: With its polarity bit at 0, a source requests when its input is 1. With its polarity bit at 1, it requests when its input is 0.
- R6: A source whose enable bit is 0 never contributes. With all enable bits at 0, no request is formed.
- R7: The request is the OR of every enabled source whose polarity-adjusted input is 1.
- R8: With mode field (control bits 8:7) = 00, `irq_oe` and `irq_o` are 0 whatever the inputs.
- R9: With mode 01 (open drain), `irq_oe`=1 and `irq_o`=0 while a request is pending. Otherwise `irq_oe`=0.
- R10: With mode 10, `irq_oe`=1 and `irq_o` equals the request.
- R11: With mode 11, `irq_oe`=1 and `irq_o` is the inverse of the request.
- R12: A change on a raw input reaches `irq_o` after exactly three rising clock edges: two synchronizer stages and the state register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| therm_i | input | 1 | Thermal shutdown status, raw |
| hp_i | input | 1 | Headphone present, raw |
| gpin_i | input | 3 | General-purpose status inputs, raw |
| micdet_i | input | 1 | Microphone bias above threshold, raw |
| micshort_i | input | 1 | Microphone bias over current, raw |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational on `reg_addr` |
| irq_o | output | 1 | Interrupt pin data value |
| irq_oe | output | 1 | Interrupt pin output enable |

## Verification
The bench builds the block with its default parameters: 8-bit addresses, 9-bit data and two synchronizer stages. Seven sources give 128 input vectors, so every vector is swept under each of several polarity/enable pairs and under each single-source enable. This covers the bit map and the OR completely. The fixed depth of two stages also makes the three-edge latency an exact cycle count that the bench can pin down.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_OD_LOW  = 2'b01,
        MODE_PP_HIGH = 2'b10,
        MODE_PP_LOW  = 2'b11
    } out_mode_e;

    typedef enum logic [1:0] {
        ST_QUIET    = 2'b00,
        ST_RELEASED = 2'b01,
        ST_ACTIVE   = 2'b10
    } drv_state_e;

    localparam int          SRC_W    = 8;
    localparam logic [7:0]  SRC_USED = 8'b1111_1011;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= d_i;
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= '0;
            else        stage_q[g] <= stage_q[g-1];
        end
    end

    assign q_o = stage_q[DEPTH-1];

    if (DEPTH >= 2) begin : g_chk
        AST_SYNC_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
            stage_q[1] == $past(stage_q[0])); // R12
    end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 9,
    parameter logic [7:0]  POL_ADDR  = 8'h19,
    parameter logic [7:0]  ENA_ADDR  = 8'h1A,
    parameter logic [7:0]  CTRL_ADDR = 8'h1B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [SRC_W-1:0]  pol_o,
    output logic [SRC_W-1:0]  ena_o,
    output out_mode_e         mode_o
);

    localparam logic [ADDR_W-1:0] A_POL  = ADDR_W'(POL_ADDR);
    localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(ENA_ADDR);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam int                MODE_LSB = DATA_W - 2;

    logic [SRC_W-1:0] pol_q;
    logic [SRC_W-1:0] ena_q;
    out_mode_e        mode_q;
    logic             hit_pol, hit_ena, hit_ctrl;

    assign hit_pol  = (addr_i == A_POL);
    assign hit_ena  = (addr_i == A_ENA);
    assign hit_ctrl = (addr_i == A_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q  <= '0;
            ena_q  <= '0;
            mode_q <= MODE_OFF;
        end else if (we_i) begin
            if (hit_pol)  pol_q  <= wdata_i[SRC_W-1:0] & SRC_USED;
            if (hit_ena)  ena_q  <= wdata_i[SRC_W-1:0] & SRC_USED;
            if (hit_ctrl) mode_q <= out_mode_e'(wdata_i[DATA_W-1 -: 2]);
        end
    end

    always_comb begin
        rdata_o = '0;
        if (hit_pol)       rdata_o[SRC_W-1:0]      = pol_q;
        else if (hit_ena)  rdata_o[SRC_W-1:0]      = ena_q;
        else if (hit_ctrl) rdata_o[DATA_W-1 -: 2]  = mode_q;
    end

    assign pol_o  = pol_q;
    assign ena_o  = ena_q;
    assign mode_o = mode_q;

    AST_CTRL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ctrl |-> (rdata_o[MODE_LSB-1:0] == '0)); // R2
    AST_SRC_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_pol || hit_ena) |-> (rdata_o[2] == 1'b0 && rdata_o[DATA_W-1] == 1'b0)); // R2
    AST_FOREIGN_WRITE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && !hit_pol && !hit_ena && !hit_ctrl) |=> $stable({pol_q, ena_q, mode_q})); // R3

endmodule

// File: rtl/irqc_qualify.sv
module irqc_qualify
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] src_i,
    input  logic [SRC_W-1:0] pol_i,
    input  logic [SRC_W-1:0] ena_i,
    output logic             req_o
);

    logic [SRC_W-1:0] hit;

    for (genvar g = 0; g < SRC_W; g++) begin : g_src
        if (SRC_USED[g]) begin : g_used
            assign hit[g] = (src_i[g] ^ pol_i[g]) & ena_i[g];
        end else begin : g_spare
            assign hit[g] = 1'b0;
        end
    end

    assign req_o = |hit;

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_i == '0) |-> !req_o); // R6
    AST_SPARE_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        hit[2] == 1'b0); // R4

endmodule

// File: rtl/irqc_drive.sv
module irqc_drive
    import irqc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  out_mode_e mode_i,
    input  logic      req_i,
    output logic      pin_o,
    output logic      pin_oe
);

    drv_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET: begin
                if (mode_i != MODE_OFF) state_d = req_i ? ST_ACTIVE : ST_RELEASED; // ARM
            end
            ST_RELEASED: begin
                if (mode_i == MODE_OFF) state_d = ST_QUIET;                       // DISARM
                else if (req_i)         state_d = ST_ACTIVE;                      // FIRE
            end
            ST_ACTIVE: begin
                if (mode_i == MODE_OFF) state_d = ST_QUIET;                       // DISARM
                else if (!req_i)        state_d = ST_RELEASED;                    // CLEAR
            end
            default: state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        pin_o  = 1'b0;
        pin_oe = 1'b0;
        if (state_q != ST_QUIET) begin
            unique case (mode_i)
                MODE_OFF: begin
                    pin_o  = 1'b0;
                    pin_oe = 1'b0;
                end
                MODE_OD_LOW: begin
                    pin_o  = 1'b0;
                    pin_oe = (state_q == ST_ACTIVE);
                end
                MODE_PP_HIGH: begin
                    pin_o  = (state_q == ST_ACTIVE);
                    pin_oe = 1'b1;
                end
                MODE_PP_LOW: begin
                    pin_o  = (state_q != ST_ACTIVE);
                    pin_oe = 1'b1;
                end
                default: begin
                    pin_o  = 1'b0;
                    pin_oe = 1'b0;
                end
            endcase
        end
    end

    AST_OFF_GOES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_OFF) |=> (state_q == ST_QUIET)); // R8
    AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && mode_i == MODE_OD_LOW) |-> !pin_o); // R9
    AST_PP_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == MODE_PP_HIGH || mode_i == MODE_PP_LOW) && state_q != ST_QUIET) |-> pin_oe); // R10
    AST_STATE_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != MODE_OFF) |=> ((state_q == ST_ACTIVE) == $past(req_i))); // R12

endmodule

// File: rtl/codec_irq_combiner.sv
module codec_irq_combiner
    import irqc_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          DATA_W     = 9,
    parameter int          SYNC_DEPTH = 2,
    parameter logic [7:0]  POL_ADDR   = 8'h19,
    parameter logic [7:0]  ENA_ADDR   = 8'h1A,
    parameter logic [7:0]  CTRL_ADDR  = 8'h1B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              therm_i,
    input  logic              hp_i,
    input  logic [2:0]        gpin_i,
    input  logic              micdet_i,
    input  logic              micshort_i,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              irq_oe
);

    logic [SRC_W-1:0] raw_vec, sync_vec, pol, ena;
    out_mode_e        mode;
    logic             req;

    assign raw_vec = {therm_i, hp_i, gpin_i[2], gpin_i[1], gpin_i[0], 1'b0, micdet_i, micshort_i};

    irqc_sync #(.W(SRC_W), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_vec),
        .q_o   (sync_vec)
    );

    irqc_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .POL_ADDR  (POL_ADDR),
        .ENA_ADDR  (ENA_ADDR),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .rdata_o (reg_rdata),
        .pol_o   (pol),
        .ena_o   (ena),
        .mode_o  (mode)
    );

    irqc_qualify u_qual (
        .clk   (clk),
        .rst_n (rst_n),
        .src_i (sync_vec),
        .pol_i (pol),
        .ena_i (ena),
        .req_o (req)
    );

    irqc_drive u_drive (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_i (mode),
        .req_i  (req),
        .pin_o  (irq_o),
        .pin_oe (irq_oe)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> (!irq_oe && !irq_o)); // R1

endmodule

// File: tb/codec_irq_combiner_test.sv
module codec_irq_combiner_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       therm_i = 1'b0, hp_i = 1'b0, micdet_i = 1'b0, micshort_i = 1'b0;
    logic [2:0] gpin_i = 3'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_addr = 8'h00;
    logic [8:0] reg_wdata = 9'h000;
    logic [8:0] reg_rdata;
    logic       irq_o, irq_oe;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    codec_irq_combiner uut (
        .clk(clk), .rst_n(rst_n), .therm_i(therm_i), .hp_i(hp_i), .gpin_i(gpin_i),
        .micdet_i(micdet_i), .micshort_i(micshort_i), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_o(irq_o), .irq_oe(irq_oe)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [8:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] a, input logic [8:0] exp_v, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata == exp_v, req, reg_rdata, exp_v);
    endtask

    task automatic apply(input logic [6:0] r);
        @(negedge clk);
        therm_i = r[6]; hp_i = r[5]; gpin_i = r[4:2]; micdet_i = r[1]; micshort_i = r[0];
        repeat (4) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [7:0] place(input logic [6:0] r);
        return {r[6:2], 1'b0, r[1:0]};
    endfunction

    function automatic logic want_req(input logic [6:0] r, input logic [7:0] p, input logic [7:0] e);
        return |(((place(r) ^ p) & e) & 8'hFB);
    endfunction

    task automatic sweep(input logic [7:0] p, input logic [7:0] e, input string req);
        wr(8'h19, {1'b0, p});
        wr(8'h1A, {1'b0, e});
        for (int v = 0; v < 128; v++) begin
            logic w;
            apply(7'(v));
            w = want_req(7'(v), p, e);
            check(irq_o == w && irq_oe, req, {irq_oe, irq_o}, {1'b1, w});
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        #1;
        check(irq_oe == 0 && irq_o == 0, "R1", {irq_oe, irq_o}, 0);
        rd_check(8'h19, 9'h000, "R1");
        rd_check(8'h1A, 9'h000, "R1");
        rd_check(8'h1B, 9'h000, "R1");

        // R2 readback and unused bits
        wr(8'h19, 9'h1FF); rd_check(8'h19, 9'h0FB, "R2");
        wr(8'h1A, 9'h1FF); rd_check(8'h1A, 9'h0FB, "R2");
        wr(8'h1B, 9'h1FF); rd_check(8'h1B, 9'h180, "R2");
        wr(8'h19, 9'h0A3); rd_check(8'h19, 9'h0A3, "R2");
        wr(8'h1A, 9'h058); rd_check(8'h1A, 9'h058, "R2");
        wr(8'h1B, 9'h080); rd_check(8'h1B, 9'h080, "R2");

        // R3 foreign addresses ignored
        wr(8'h18, 9'h1FF); wr(8'h1C, 9'h1FF); wr(8'h00, 9'h1FF); wr(8'h99, 9'h1FF);
        rd_check(8'h19, 9'h0A3, "R3");
        rd_check(8'h1A, 9'h058, "R3");
        rd_check(8'h1B, 9'h080, "R3");

        // R10 push-pull active high for sweeps; R5 R7 combined sweeps
        wr(8'h1B, 9'h100);
        sweep(8'h00, 8'hFB, "R7");
        sweep(8'hFB, 8'hFB, "R5");
        sweep(8'hA2, 8'hFB, "R5");
        sweep(8'h49, 8'h9B, "R7");
        sweep(8'h00, 8'h00, "R6");
        sweep(8'hFB, 8'h00, "R6");

        // R4 single-source bit map
        for (int j = 0; j < 7; j++) begin
            logic [7:0] b;
            b = place(7'(1 << j));
            sweep(8'h00, b, "R4");
        end

        // Output modes R8..R11 with thermal as the only enabled source
        wr(8'h19, 9'h000);
        wr(8'h1A, 9'h080);
        for (int m = 0; m < 4; m++) begin
            wr(8'h1B, 9'(m << 7));
            for (int q = 0; q < 2; q++) begin
                logic eo, ed;
                apply({1'(q), 6'b0});
                case (m)
                    0: begin eo = 0; ed = 0; end
                    1: begin eo = 1'(q); ed = 0; end
                    2: begin eo = 1; ed = 1'(q); end
                    default: begin eo = 1; ed = ~1'(q); end
                endcase
                if (m == 0)      check(irq_oe == eo && irq_o == ed, "R8",  {irq_oe, irq_o}, {eo, ed});
                else if (m == 1) check(irq_oe == eo && irq_o == ed, "R9",  {irq_oe, irq_o}, {eo, ed});
                else if (m == 2) check(irq_oe == eo && irq_o == ed, "R10", {irq_oe, irq_o}, {eo, ed});
                else             check(irq_oe == eo && irq_o == ed, "R11", {irq_oe, irq_o}, {eo, ed});
            end
        end

        // R8 all inputs active with everything enabled, mode off
        wr(8'h1A, 9'h0FB);
        wr(8'h1B, 9'h000);
        apply(7'h7F);
        check(irq_oe == 0 && irq_o == 0, "R8", {irq_oe, irq_o}, 0);

        // R12 latency of three edges
        wr(8'h1A, 9'h080);
        wr(8'h1B, 9'h100);
        apply(7'h00);
        check(irq_o == 0, "R12", irq_o, 0);
        @(negedge clk);
        therm_i = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check(irq_o == 0, "R12", irq_o, 0);
        @(posedge clk);
        @(negedge clk);
        check(irq_o == 1, "R12", irq_o, 1);
        therm_i = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        check(irq_o == 1, "R12", irq_o, 1);
        @(posedge clk);
        @(negedge clk);
        check(irq_o == 0, "R12", irq_o, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule